// File: doc/BRIEF.md
# Periodic Random Number Display Controller

This block drives an eight-position multiplexed seven-segment display. The five upper positions always carry a fixed identification number, 20413. The three lower positions carry a pseudo-random decimal value between 0 and 999. A new value replaces the old one once per refresh period, which is two seconds of wall-clock time by default.

The random source is a 10-bit shift register that advances by one step per refresh. Its raw value is folded into the range 0 to 999 and split into three decimal digits. A scanner lights one position at a time and cycles through all eight positions at about 1 kHz per full frame. A synchronous active-low reset clears the shown value to 000 at once. The first random value appears exactly one refresh period after reset is released.

Top module: `rand_disp_ctrl`

## Requirements
- R1: Positions 7, 6, 5, 4 and 3 show the decimal digits 2, 0, 4, 1 and 3 respectively, in every frame.
- R2: In every cycle out of reset, exactly one bit of `dig_en` is high. Bit i selects position i. After reset the scan starts at position 0. It moves to the next higher position every DWELL_CYC cycles and wraps from 7 to 0. DWELL_CYC = max(1, CLK_HZ / (SCAN_HZ * 8)).
- R3: `seg` is active-high with bit 0 = segment a through bit 6 = segment g. Digits 0 to 9 use the patterns 0x3F, 0x06, 0x5B, 0x4F, 0x66, 0x6D, 0x7D, 0x07, 0x7F and 0x6F.
- R4: While `rst_n` is low at a clock edge, the shown value becomes 000 and the scan returns to position 0 after that edge.
- R5: The shown value first changes exactly PERIOD_CYC = CLK_HZ * PERIOD_SEC clock edges after reset is released. After that it changes every PERIOD_CYC edges, and it is held constant between those edges.
- R6: The generator is a 10-bit register seeded with 0x2A5 on reset. On each refresh it shifts toward bit 9, and the new bit 0 is the XOR of the old bits 9, 5, 2 and 1. The value shown comes from the register contents after that shift, and the register is never zero.
- R7: If the register value is 1000 or more, 1000 is subtracted. The shown value therefore never exceeds 999.
- R8: The shown value appears in decimal, with hundreds on position 2, tens on position 1 and units on position 0. Leading zeros are not blanked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock at CLK_HZ |
| rst_n | input | 1 | Synchronous active-low reset key |
| seg | output | 7 | Active-high segment lines, bit 0 = a through bit 6 = g |
| dig_en | output | 8 | One-hot position enable, bit i = position i |

## Verification
The bench shortens the refresh period to 80 cycles and the dwell to 2 cycles. It then runs for more than a thousand refresh periods, so the generator visits nearly all of its reachable states, including raw values above 999 that exercise the fold. At every cycle, the bench compares the selected position and its segment pattern with a model built from the cycle count since release. This separates errors in scan order, in the fixed digits, in the timing of updates and in the decimal split. A reset pulse in the middle of a period shows that the digits return to 000 immediately, and that the first value after release waits a full period rather than the remainder of the old one.

// File: rtl/rdc_pkg.sv
// Package: shared constants and segment decoding for the random display controller.
// Assumes a display of eight positions, of which five hold the fixed number.
package rdc_pkg;
    localparam int unsigned NUM_POS  = 8;
    localparam int unsigned RND_POS  = 3;
    localparam int unsigned SEG_W    = 7;
    localparam int unsigned RND_W    = 10;

    // Decimal digit to active-high segments, bit 0 = a ... bit 6 = g.
    function automatic logic [SEG_W-1:0] seg_of(input logic [3:0] d);
        logic [SEG_W-1:0] s;
        case (d)
            4'd0:    s = 7'h3F;
            4'd1:    s = 7'h06;
            4'd2:    s = 7'h5B;
            4'd3:    s = 7'h4F;
            4'd4:    s = 7'h66;
            4'd5:    s = 7'h6D;
            4'd6:    s = 7'h7D;
            4'd7:    s = 7'h07;
            4'd8:    s = 7'h7F;
            4'd9:    s = 7'h6F;
            default: s = 7'h00;
        endcase
        return s;
    endfunction
endpackage

// File: rtl/period_timer.sv
// Module: period_timer
// Issues a one-cycle tick every PERIOD_CYC cycles, counted from reset release.
// Assumes PERIOD_CYC >= 1; the counter clears on synchronous active-low reset.
module period_timer #(
    parameter int unsigned PERIOD_CYC = 100_000_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int unsigned CNT_W = (PERIOD_CYC > 1) ? $clog2(PERIOD_CYC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD_CYC - 1);

    logic [CNT_W-1:0] cnt_q;

    assign tick = (cnt_q == LAST);

    // Count cycles and wrap at the end of each period.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (tick) cnt_q <= '0;
        else           cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/rand_src.sv
// Module: rand_src
// A 10-bit shift register that steps once per tick. The stepped value, folded
// into 0..999, is registered as the shown value. Reset loads SEED into the
// register and clears the shown value. Assumes SEED is non-zero.
module rand_src #(
    parameter logic [9:0] SEED = 10'h2A5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    output logic [9:0] lfsr_q,
    output logic [9:0] shown_val
);
    localparam logic [9:0] LIMIT = 10'd1000;

    logic       fb;
    logic [9:0] next_l;
    logic [9:0] folded;

    // Feedback and one-step shift toward the top bit.
    always_comb begin
        fb     = lfsr_q[9] ^ lfsr_q[5] ^ lfsr_q[2] ^ lfsr_q[1];
        next_l = {lfsr_q[8:0], fb};
    end

    // Fold values of 1000 and above back into range.
    always_comb begin
        folded = (next_l >= LIMIT) ? (next_l - LIMIT) : next_l;
    end

    // Advance the generator and capture the shown value on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lfsr_q    <= SEED;
            shown_val <= '0;
        end else if (tick) begin
            lfsr_q    <= next_l;
            shown_val <= folded;
        end
    end
endmodule

// File: rtl/bin2dec.sv
// Module: bin2dec
// Combinational split of a binary value into DIGS decimal digits, with the
// units digit in the lowest nibble. Assumes the value is below 10**DIGS.
module bin2dec #(
    parameter int unsigned IN_W = 10,
    parameter int unsigned DIGS = 3
) (
    input  logic [IN_W-1:0]   val,
    output logic [4*DIGS-1:0] bcd
);
    for (genvar g = 0; g < DIGS; g++) begin : g_dig
        localparam int unsigned P10 = 10 ** g;
        // One decimal digit per nibble.
        assign bcd[4*g +: 4] = 4'((int'(val) / P10) % 10);
    end
endmodule

// File: rtl/digit_scan.sv
// Module: digit_scan
// Steps a position index from 0 up to NUM_POS-1 every DWELL_CYC cycles and
// decodes it into one-hot enables. Reset returns the scan to position 0.
module digit_scan #(
    parameter int unsigned NUM_POS   = 8,
    parameter int unsigned DWELL_CYC = 6250
) (
    input  logic                       clk,
    input  logic                       rst_n,
    output logic [$clog2(NUM_POS)-1:0] idx,
    output logic [NUM_POS-1:0]         dig_en
);
    localparam int unsigned IDX_W = $clog2(NUM_POS);
    localparam int unsigned DW_W  = (DWELL_CYC > 1) ? $clog2(DWELL_CYC) : 1;
    localparam logic [DW_W-1:0]  DW_LAST  = DW_W'(DWELL_CYC - 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NUM_POS - 1);

    logic [DW_W-1:0] dw_q;

    // Dwell on each position, then move to the next one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dw_q <= '0;
            idx  <= '0;
        end else if (dw_q == DW_LAST) begin
            dw_q <= '0;
            idx  <= (idx == IDX_LAST) ? '0 : idx + 1'b1;
        end else begin
            dw_q <= dw_q + 1'b1;
        end
    end

    for (genvar g = 0; g < NUM_POS; g++) begin : g_en
        // Enable for position g.
        assign dig_en[g] = (idx == IDX_W'(g));
    end
endmodule

// File: rtl/rand_disp_ctrl.sv
// Module: rand_disp_ctrl (top)
// Shows a fixed five-digit number on the upper positions and a refreshed
// random value of 0..999 on the lower three. Synchronous active-low reset.
// Assumes CLK_HZ * PERIOD_SEC fits in 32 bits.
module rand_disp_ctrl
    import rdc_pkg::*;
#(
    parameter int unsigned CLK_HZ     = 50_000_000,
    parameter int unsigned PERIOD_SEC = 2,
    parameter int unsigned SCAN_HZ    = 1000,
    parameter logic [19:0] ID_BCD     = 20'h20413,
    parameter logic [9:0]  SEED       = 10'h2A5
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [SEG_W-1:0] seg,
    output logic [NUM_POS-1:0] dig_en
);
    localparam int unsigned PERIOD_CYC = CLK_HZ * PERIOD_SEC;
    localparam int unsigned DWELL_RAW  = CLK_HZ / (SCAN_HZ * NUM_POS);
    localparam int unsigned DWELL_CYC  = (DWELL_RAW < 1) ? 1 : DWELL_RAW;
    localparam int unsigned IDX_W      = $clog2(NUM_POS);

    logic                 tick;
    logic [RND_W-1:0]     lfsr_q;
    logic [RND_W-1:0]     shown_val;
    logic [4*RND_POS-1:0] rnd_bcd;
    logic [IDX_W-1:0]     idx;
    logic [4*NUM_POS-1:0] all_bcd;
    logic [3:0]           nib;

    period_timer #(.PERIOD_CYC(PERIOD_CYC)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    rand_src #(.SEED(SEED)) u_rand (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .lfsr_q    (lfsr_q),
        .shown_val (shown_val)
    );

    bin2dec #(.IN_W(RND_W), .DIGS(RND_POS)) u_dec (
        .val (shown_val),
        .bcd (rnd_bcd)
    );

    digit_scan #(.NUM_POS(NUM_POS), .DWELL_CYC(DWELL_CYC)) u_scan (
        .clk    (clk),
        .rst_n  (rst_n),
        .idx    (idx),
        .dig_en (dig_en)
    );

    // Select the digit of the active position and drive its segments.
    always_comb begin
        all_bcd = {ID_BCD, rnd_bcd};
        nib     = all_bcd[4*idx +: 4];
        seg     = seg_of(nib);
    end
endmodule

// File: rtl/rand_disp_ctrl_chk.sv
// Module: rand_disp_ctrl_chk
// Property checker bound to rand_disp_ctrl. It observes the tick, the generator
// register, the shown value and the enables.
module rand_disp_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic [9:0] lfsr_q,
    input logic [9:0] shown_val,
    input logic [7:0] dig_en
);
    a_r2_one_position: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(dig_en) == 1);

    a_r4_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (shown_val == 10'd0 && dig_en == 8'b0000_0001));

    a_r5_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(shown_val));

    a_r6_never_zero: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != 10'd0);

    a_r6_shift_step: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (lfsr_q[9:1] == $past(lfsr_q[8:0])));

    a_r7_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        shown_val <= 10'd999);
endmodule

bind rand_disp_ctrl rand_disp_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .lfsr_q    (lfsr_q),
    .shown_val (shown_val),
    .dig_en    (dig_en)
);

// File: tb/rand_disp_ctrl_bench.sv
// Bench: compares every cycle against a model built from the cycle count.
module rand_disp_ctrl_bench;
    localparam int unsigned CLK_HZ = 40;
    localparam int unsigned PSEC   = 2;
    localparam int unsigned SCAN   = 2;
    localparam int unsigned P      = CLK_HZ * PSEC;
    localparam int unsigned DWELL  = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] seg;
    logic [7:0] dig_en;

    int checks = 0;
    int fails  = 0;

    int unsigned n = 0;
    logic [9:0]  m_lfsr = 10'h2A5;
    int unsigned m_shown = 0;
    bit          seen_edge = 0;

    always #5 clk = ~clk;

    rand_disp_ctrl #(.CLK_HZ(CLK_HZ), .PERIOD_SEC(PSEC), .SCAN_HZ(SCAN)) u_rand_disp_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .seg    (seg),
        .dig_en (dig_en)
    );

    function automatic logic [6:0] pat(input int unsigned d);
        case (d)
            0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
            4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
            8: return 7'h7F; 9: return 7'h6F;
            default: return 7'h00;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h (n=%0d)", req, act, exp, n);
        end
    endtask

    // One clock: update the model at the edge, compare at the falling edge.
    task automatic step();
        logic [9:0]  nx;
        int unsigned pos, dg;
        @(posedge clk);
        if (!rst_n) begin
            n = 0; m_lfsr = 10'h2A5; m_shown = 0;
        end else begin
            n++;
            if (n % P == 0) begin
                // R6: shift with feedback from bits 9,5,2,1; R7: fold >= 1000
                nx = {m_lfsr[8:0], m_lfsr[9] ^ m_lfsr[5] ^ m_lfsr[2] ^ m_lfsr[1]};
                m_lfsr  = nx;
                m_shown = (nx >= 10'd1000) ? int'(nx) - 1000 : int'(nx);
            end
        end
        seen_edge = 1;
        @(negedge clk);
        pos = (n / DWELL) % 8;
        case (pos)
            7: dg = 2; 6: dg = 0; 5: dg = 4; 4: dg = 1; 3: dg = 3;
            2: dg = m_shown / 100;
            1: dg = (m_shown / 10) % 10;
            default: dg = m_shown % 10;
        endcase
        if (!rst_n || n == 0) begin
            chk("R4 scan at position 0", 32'(dig_en), 32'h1);
            chk("R4 digits 000", 32'(seg), 32'(pat(dg)));
        end else begin
            chk("R2 one-hot scan", 32'(dig_en), 32'(8'd1 << pos));
            if (pos >= 3) chk("R1 R3 fixed digit", 32'(seg), 32'(pat(dg)));
            else          chk("R5 R6 R7 R8 random digit", 32'(seg), 32'(pat(dg)));
        end
    endtask

    initial begin
        rst_n = 1'b0;
        repeat (4) step();
        @(negedge clk) rst_n = 1'b1;
        // R5: run well past the first periods, then pulse reset mid-period
        repeat (4 * P + 37) step();
        rst_n = 1'b0;
        repeat (5) step();
        rst_n = 1'b1;
        // R5 R7: long run so the generator visits most of its states
        repeat (1100 * P) step();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #1_500_000;
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule